// File: doc/BRIEF.md
# Trap Path Selector and Handler Vector Generator

This block sits next to a processor's trap sequencer. For each trap request it works out the privilege level the processor is running at and picks one of five handling paths: the reset/error-recovery (RED) path, the error-state stop, the guest-watchdog escalation, the hypervisor path or the privileged path. For every path except the error stop it also forms the handler address and the two sequential fetch addresses after it.

The inputs are the current trap level, the processor-state and hypervisor-state words, the trap type, the target privilege level of the trap (resolved elsewhere) and the two trap base registers, one for privileged handlers and one for hypervisor handlers. Results are registered and appear one cycle after a request strobe. The state updates that a trap performs are left to other logic.

Top module: `trap_vec_sel`

## Requirements
- R1: `cur_lvl_o` is 2 (hypervisor) when `hpstate_i[2]` is set; otherwise 1 (privileged) when `pstate_i[2]` is set; otherwise 0 (user).
- R2: When `hpstate_i[5]` is set or `tl_i` equals MAX_TL-1, the RED path (`path_o` = 5'b00001) is selected, ahead of every other condition, and `pc_o` = 0xFFF00000A0 (fixed RED base OR'd with trap type 5 shifted left by 5, kept to 8 bits).
- R3: Otherwise, when `tl_i` equals MAX_TL, the error path (`path_o` = 5'b00010) is selected and `pc_o`, `npc_o` and `nnpc_o` are all zero.
- R4: Otherwise, when `tl_i` exceeds MAX_PTL and `tgt_lvl_i` is 1 (privileged), the guest-watchdog path (`path_o` = 5'b00100) is selected with `pc_o` = (`htba_i` with bits 13:0 cleared) OR 0x40, i.e. the hypervisor vector of trap type 2.
- R5: Otherwise, when `tgt_lvl_i` is 2 or 3 (hypervisor), or it is 1 and `tt_i` is 384 or above, the hypervisor path (`path_o` = 5'b01000) is selected with `pc_o` = (`htba_i` with bits 13:0 cleared) OR ((`tt_i` << 5) kept to bits 13:0).
- R6: In every other case, including `tgt_lvl_i` = 0, the privileged path (`path_o` = 5'b10000) is selected with `pc_o` = (`tba_i` with bits 14:0 cleared) OR (bit 14 when `tl_i`+1 exceeds 1) OR ((`tt_i` << 5) kept to bits 13:0).
- R7: On every path other than the error path, `npc_o` = `pc_o` + 4 and `nnpc_o` = `pc_o` + 8.
- R8: `path_o` carries exactly one set bit after every request, and `tt_o` returns the requested `tt_i` unchanged on every path.
- R9: After reset all outputs are zero. Outputs update on the clock edge that samples `req_valid_i` high, `vld_o` is high for exactly that following cycle, and the outputs hold their values while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Trap request strobe |
| tl_i | input | TL_W | Current trap level |
| pstate_i | input | PS_W | Processor state word (bit 2: privileged) |
| hpstate_i | input | HPS_W | Hypervisor state word (bit 2: hypervisor, bit 5: RED) |
| tt_i | input | TT_W | Trap type |
| tgt_lvl_i | input | 2 | Target level: 0 user, 1 privileged, 2/3 hypervisor |
| tba_i | input | AW | Privileged trap base |
| htba_i | input | AW | Hypervisor trap base |
| vld_o | output | 1 | Result valid, one cycle per request |
| path_o | output | 5 | One-hot path: bit0 RED, bit1 error, bit2 guest watchdog, bit3 hypervisor, bit4 privileged |
| cur_lvl_o | output | 2 | Decoded current privilege level |
| tt_o | output | TT_W | Trap type to record |
| pc_o | output | AW | Handler address |
| npc_o | output | AW | Handler address + 4 |
| nnpc_o | output | AW | Handler address + 8 |

## Verification
The bench builds the block with its defaults: MAX_TL of 6, MAX_PTL of 2, a 3-bit trap level, 9-bit trap types and 64-bit addresses. With these values every trap level from 0 to 7 is reachable, so the RED boundary at level 5, the error stop at level 6, the guest-watchdog window above level 2 and the bit-14 choice at levels 0 and 1 are all driven directly. Nine-bit trap types reach both sides of the 384 threshold and the top of the 14-bit offset field, and the base registers carry set low bits to show the masking.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;
  localparam int NPATH = 5;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_PRIV = 2'd1,
    LVL_HYP  = 2'd2
  } lvl_e;

  // one-hot path bit positions
  localparam int P_RED = 0;
  localparam int P_ERR = 1;
  localparam int P_GWD = 2;
  localparam int P_HYP = 3;
  localparam int P_PRV = 4;

  localparam logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000;
  localparam int          RED_TT   = 5;
  localparam int          GWD_TT   = 2;
  localparam int          HYP_THR  = 384;
  localparam int          INST_B   = 4;
endpackage

// File: rtl/trap_priv_decode.sv
module trap_priv_decode
  import trap_vec_pkg::*;
#(
  parameter int PS_W  = 13,
  parameter int HPS_W = 11
) (
  input  logic [PS_W-1:0]  pstate_i,
  input  logic [HPS_W-1:0] hpstate_i,
  output lvl_e             lvl_o
);
  always_comb begin
    if (hpstate_i[2])     lvl_o = LVL_HYP;
    else if (pstate_i[2]) lvl_o = LVL_PRIV;
    else                  lvl_o = LVL_USER;
  end
endmodule

// File: rtl/trap_path_select.sv
module trap_path_select
  import trap_vec_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int TL_W    = 3,
  parameter int TT_W    = 9,
  parameter int HPS_W   = 11
) (
  input  logic [TL_W-1:0]  tl_i,
  input  logic [HPS_W-1:0] hpstate_i,
  input  logic [TT_W-1:0]  tt_i,
  input  logic [1:0]       tgt_lvl_i,
  output logic [NPATH-1:0] path_o,
  output logic [TT_W-1:0]  vec_tt_o
);
  localparam logic [TL_W-1:0] TL_RED = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_ERR = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PMX = TL_W'(MAX_PTL);

  logic tgt_priv, tgt_hyp, tt_high;
  assign tgt_priv = (tgt_lvl_i == 2'd1);
  assign tgt_hyp  = tgt_lvl_i[1];
  assign tt_high  = (32'(tt_i) >= HYP_THR);

  always_comb begin
    path_o   = '0;
    vec_tt_o = tt_i;
    if (hpstate_i[5] || tl_i == TL_RED) begin
      path_o[P_RED] = 1'b1;
      vec_tt_o      = TT_W'(RED_TT);
    end else if (tl_i == TL_ERR) begin
      path_o[P_ERR] = 1'b1;
    end else if (tl_i > TL_PMX && tgt_priv) begin
      path_o[P_GWD] = 1'b1;
      vec_tt_o      = TT_W'(GWD_TT);
    end else if (tgt_hyp || (tgt_priv && tt_high)) begin
      path_o[P_HYP] = 1'b1;
    end else begin
      path_o[P_PRV] = 1'b1;
    end
  end
endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen
  import trap_vec_pkg::*;
#(
  parameter int TL_W = 3,
  parameter int TT_W = 9,
  parameter int AW   = 64
) (
  input  logic [NPATH-1:0] path_i,
  input  logic [TT_W-1:0]  vec_tt_i,
  input  logic [TL_W-1:0]  tl_i,
  input  logic [AW-1:0]    tba_i,
  input  logic [AW-1:0]    htba_i,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic [AW-1:0]    nnpc_o
);
  localparam int          HV_LO  = 14;
  localparam int          PV_LO  = 15;
  localparam logic [AW-1:0] M14  = AW'({HV_LO{1'b1}});
  localparam logic [AW-1:0] M15  = AW'({PV_LO{1'b1}});
  localparam logic [AW-1:0] RED_PC = AW'(RED_BASE) | (AW'(RED_TT << 5) & AW'(8'hFF));
  localparam logic [AW-1:0] STEP = AW'(INST_B);

  logic [AW-1:0] tt_off, hyp_pc, prv_pc;
  logic          deep;

  assign tt_off = AW'({vec_tt_i, 5'b0}) & M14;
  // new level = tl_i + 1 > 1
  assign deep   = (tl_i != '0);
  assign hyp_pc = (htba_i & ~M14) | tt_off;
  assign prv_pc = (tba_i & ~M15) | (deep ? (AW'(1) << HV_LO) : '0) | tt_off;

  always_comb begin
    pc_o = '0;
    unique case (1'b1)
      path_i[P_RED]:                  pc_o = RED_PC;
      path_i[P_GWD], path_i[P_HYP]:   pc_o = hyp_pc;
      path_i[P_PRV]:                  pc_o = prv_pc;
      default:                        pc_o = '0;
    endcase
  end

  assign npc_o  = path_i[P_ERR] ? '0 : pc_o + STEP;
  assign nnpc_o = path_i[P_ERR] ? '0 : pc_o + (STEP << 1);
endmodule

// File: rtl/trap_vec_sel.sv
module trap_vec_sel
  import trap_vec_pkg::*;
#(
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int TL_W    = 3,
  parameter int TT_W    = 9,
  parameter int AW      = 64,
  parameter int PS_W    = 13,
  parameter int HPS_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [TL_W-1:0]  tl_i,
  input  logic [PS_W-1:0]  pstate_i,
  input  logic [HPS_W-1:0] hpstate_i,
  input  logic [TT_W-1:0]  tt_i,
  input  logic [1:0]       tgt_lvl_i,
  input  logic [AW-1:0]    tba_i,
  input  logic [AW-1:0]    htba_i,
  output logic             vld_o,
  output logic [4:0]       path_o,
  output logic [1:0]       cur_lvl_o,
  output logic [TT_W-1:0]  tt_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic [AW-1:0]    nnpc_o
);
  lvl_e             lvl_d;
  logic [NPATH-1:0] path_d;
  logic [TT_W-1:0]  vec_tt;
  logic [AW-1:0]    pc_d, npc_d, nnpc_d;

  trap_priv_decode #(.PS_W(PS_W), .HPS_W(HPS_W)) u_dec (
    .pstate_i (pstate_i),
    .hpstate_i(hpstate_i),
    .lvl_o    (lvl_d)
  );

  trap_path_select #(
    .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .TL_W(TL_W), .TT_W(TT_W), .HPS_W(HPS_W)
  ) u_sel (
    .tl_i     (tl_i),
    .hpstate_i(hpstate_i),
    .tt_i     (tt_i),
    .tgt_lvl_i(tgt_lvl_i),
    .path_o   (path_d),
    .vec_tt_o (vec_tt)
  );

  trap_addr_gen #(.TL_W(TL_W), .TT_W(TT_W), .AW(AW)) u_addr (
    .path_i  (path_d),
    .vec_tt_i(vec_tt),
    .tl_i    (tl_i),
    .tba_i   (tba_i),
    .htba_i  (htba_i),
    .pc_o    (pc_d),
    .npc_o   (npc_d),
    .nnpc_o  (nnpc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      path_o    <= '0;
      cur_lvl_o <= '0;
      tt_o      <= '0;
      pc_o      <= '0;
      npc_o     <= '0;
      nnpc_o    <= '0;
    end else begin
      vld_o <= req_valid_i;
      if (req_valid_i) begin
        path_o    <= path_d;
        cur_lvl_o <= lvl_d;
        tt_o      <= tt_i;
        pc_o      <= pc_d;
        npc_o     <= npc_d;
        nnpc_o    <= nnpc_d;
      end
    end
  end

  AST_PATH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $countones(path_o) == 1);  // R8
  AST_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> vld_o);  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(pc_o) && $stable(path_o));  // R9
  AST_TT_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> tt_o == $past(tt_i));  // R8
  AST_NPC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !path_o[P_ERR]) |-> (npc_o == pc_o + AW'(4) && nnpc_o == pc_o + AW'(8)));  // R7
  AST_ERR_NOADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && path_o[P_ERR]) |-> (pc_o == '0 && npc_o == '0 && nnpc_o == '0));  // R3
  AST_RED_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hpstate_i[5]) |=> path_o[P_RED]);  // R2
endmodule

// File: tb/trap_vec_sel_tb.sv
module trap_vec_sel_tb;
  localparam int AW = 64;
  localparam int MAX_TL = 6;
  localparam int MAX_PTL = 2;

  logic clk = 0, rst_ni = 0, req = 0;
  logic [2:0] tl = 0;
  logic [12:0] ps = 0;
  logic [10:0] hps = 0;
  logic [8:0] tt = 0;
  logic [1:0] tgt = 0;
  logic [AW-1:0] tba = 0, htba = 0;
  logic vld;
  logic [4:0] path;
  logic [1:0] lvl;
  logic [8:0] tto;
  logic [AW-1:0] pc, npc, nnpc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  trap_vec_sel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req), .tl_i(tl), .pstate_i(ps),
    .hpstate_i(hps), .tt_i(tt), .tgt_lvl_i(tgt), .tba_i(tba), .htba_i(htba),
    .vld_o(vld), .path_o(path), .cur_lvl_o(lvl), .tt_o(tto), .pc_o(pc),
    .npc_o(npc), .nnpc_o(nnpc)
  );

  task automatic chk(input string req_s, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  // one request: drive at negedge, sample at the negedge after the edge
  task automatic fire(input logic [2:0] t_l, input logic [12:0] p, input logic [10:0] hp,
                      input logic [8:0] ty, input logic [1:0] tg);
    @(negedge clk);
    tl = t_l; ps = p; hps = hp; tt = ty; tgt = tg; req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic chk_addr(input string r, input logic [AW-1:0] exp_pc);
    chk(r, pc, exp_pc);
    chk("R7 npc", npc, exp_pc + 64'd4);
    chk("R7 nnpc", nnpc, exp_pc + 64'd8);
    chk("R8 tt echo", AW'(tto), AW'(tt));
    chk("R9 vld", AW'(vld), 64'd1);
  endtask

  task automatic t_reset();
    chk("R9 reset vld", AW'(vld), 0);
    chk("R9 reset path", AW'(path), 0);
    chk("R9 reset pc", pc, 0);
  endtask

  task automatic t_levels();
    fire(0, 13'h004, 11'h004, 9'h10, 2'd2); chk("R1 hyp", AW'(lvl), 2);
    fire(0, 13'h004, 11'h000, 9'h10, 2'd2); chk("R1 priv", AW'(lvl), 1);
    fire(0, 13'h000, 11'h000, 9'h10, 2'd2); chk("R1 user", AW'(lvl), 0);
  endtask

  task automatic t_red();
    fire(0, 0, 11'h020, 9'h30, 2'd1);
    chk("R2 red by state path", AW'(path), 64'h01); chk_addr("R2 red pc", 64'hFF_F000_00A0);
    fire(3'(MAX_TL-1), 0, 0, 9'h30, 2'd0);
    chk("R2 red by tl path", AW'(path), 64'h01); chk_addr("R2 red pc tl", 64'hFF_F000_00A0);
    fire(3'(MAX_TL), 0, 11'h020, 9'h30, 2'd1);
    chk("R2 red beats error", AW'(path), 64'h01);
  endtask

  task automatic t_err();
    fire(3'(MAX_TL), 0, 0, 9'h30, 2'd1);
    chk("R3 err path", AW'(path), 64'h02);
    chk("R3 pc", pc, 0); chk("R3 npc", npc, 0); chk("R3 nnpc", nnpc, 0);
    chk("R8 tt err", AW'(tto), 64'h30);
  endtask

  task automatic t_gwd();
    fire(3'(MAX_PTL+1), 0, 0, 9'h1A5, 2'd1);
    chk("R4 gwd path", AW'(path), 64'h04);
    chk_addr("R4 gwd pc", (htba & ~64'h3FFF) | 64'h40);
    fire(3'(MAX_PTL+1), 0, 0, 9'h41, 2'd0);
    chk("R6 user deep to priv path", AW'(path), 64'h10);
  endtask

  task automatic t_hyp();
    fire(1, 0, 0, 9'h41, 2'd2);
    chk("R5 hyp tgt path", AW'(path), 64'h08);
    chk_addr("R5 hyp pc", (htba & ~64'h3FFF) | 64'h0820);
    fire(1, 0, 0, 9'h180, 2'd1);
    chk("R5 tt384 path", AW'(path), 64'h08);
    chk_addr("R5 tt384 pc", (htba & ~64'h3FFF) | 64'h3000);
    fire(1, 0, 0, 9'h1FF, 2'd3);
    chk_addr("R5 tt max pc", (htba & ~64'h3FFF) | 64'h3FE0);
  endtask

  task automatic t_priv();
    fire(0, 0, 0, 9'h17F, 2'd1);
    chk("R6 tt383 path", AW'(path), 64'h10);
    chk_addr("R6 tl0 pc", (tba & ~64'h7FFF) | 64'h2FE0);
    fire(1, 0, 0, 9'h24, 2'd1);
    chk("R6 tl1 path", AW'(path), 64'h10);
    chk_addr("R6 tl1 pc", (tba & ~64'h7FFF) | 64'h4000 | 64'h0480);
  endtask

  task automatic t_hold();
    logic [AW-1:0] keep;
    keep = pc;
    @(negedge clk); tl = 3'(MAX_TL); hps = 11'h020; tt = 9'h1; tgt = 2'd2;
    @(negedge clk); @(negedge clk);
    chk("R9 hold pc", pc, keep);
    chk("R9 vld low idle", AW'(vld), 0);
  endtask

  initial begin
    tba  = 64'h0000_1234_5678_FFFF;
    htba = 64'h0000_ABCD_0000_7FFF;
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_levels();
    t_red();
    t_err();
    t_gwd();
    t_hyp();
    t_priv();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule